// File: doc/BRIEF.md
# Noise-Shaped Coarse/Fine Requantizer

This block sits after a two-step quantizer and before the separate element-rotation logic of a coarse DAC bank and a fine DAC bank. Each sample, it joins the quantizer's coarse and fine codes into one N-bit word, with the coarse code as the upper part. A first-order digital error-feedback loop then decides a new coarse code of NC bits.

The new fine code is the full word minus the new coarse code scaled by 2^NF. It is NF+1 bits wide and signed. The coarse and fine codes therefore still add up exactly to the input word. The truncation error of the coarse decision is carried into the next sample, so it is shaped by (1 − z^-1). Any leakage caused by gain mismatch between the two DAC banks is pushed out of the signal band.

A two-state controller tracks the output strobe. It has two states:
- RQ_IDLE: no result was produced on the last edge.
- RQ_SHOW: a fresh result is on the outputs.

Every edge with the input strobe high moves the controller to RQ_SHOW, whichever state it was in (transitions IDLE→SHOW and SHOW→SHOW). Every edge with the strobe low moves it to RQ_IDLE (transitions SHOW→IDLE and IDLE→IDLE).

Top module: `coarse_fine_requant`

## Requirements
- R1: A synchronous reset clears `out_valid`, `coarse_out`, `fine_out` and the stored error to zero. The first sample after reset is therefore split with an error of zero.
- R2: `out_valid` is high in the cycle after an edge where `in_valid` is high, and low after an edge where it is low.
- R3: The full word is `{coarse_in, fine_in}`, with `coarse_in` as the most significant NC bits.
- R4: Without saturation, `coarse_out` = floor((word + e) / 2^NF), where e is the stored error.
- R5: `fine_out` is two's complement, NF+1 bits wide, and equals word − `coarse_out`·2^NF, so `coarse_out`·2^NF + `fine_out` = word.
- R6: On each accepted sample the stored error becomes word + e − `coarse_out`·2^NF. Without saturation this lies in 0..2^NF−1.
- R7: If word + e would need a coarse code above 2^NC−1, `coarse_out` saturates at 2^NC−1. The stored error is then clamped to 2^NF−1, and the excess remains in `fine_out`.
- R8: When `in_valid` is low, the stored error, `coarse_out` and `fine_out` keep their values.
- R9: For a constant non-saturating input applied for 2^NF accepted samples, starting from an error of zero, the `fine_out` values sum to zero. Over the same samples, `coarse_out` exceeds `coarse_in` in exactly `fine_in` samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input sample strobe |
| coarse_in | input | NC | Coarse code from the quantizer |
| fine_in | input | NF | Fine code from the quantizer |
| out_valid | output | 1 | New coarse/fine pair present |
| coarse_out | output | NC | Requantized coarse code |
| fine_out | output | NF+1 | Signed residue for the fine bank |

## Verification
The bench builds the block with NC = 4 and NF = 4. With these values all 256 input words can be swept in order. The top coarse code of 15 occurs often enough to drive saturation and error clamping repeatedly. A shaping window of 16 samples is short enough to check the zero-sum and carry count of R9 directly. Strobe gaps, a reset in mid-run and pseudo-random words are compared cycle by cycle against a behavioural integer model.

// File: rtl/rq_pkg.sv
package rq_pkg;
    typedef enum logic {
        RQ_IDLE = 1'b0,
        RQ_SHOW = 1'b1
    } rq_state_e;
endpackage

// File: rtl/rq_trunc.sv
module rq_trunc #(
    parameter int NC = 4,
    parameter int NF = 4
) (
    input  logic [NC+NF-1:0] word,
    input  logic [NF-1:0]    err,
    output logic [NC-1:0]    coarse,
    output logic [NF:0]      fine,
    output logic [NF-1:0]    err_next,
    output logic             sat
);
    localparam int N  = NC + NF;
    localparam int FW = NF + 1;
    localparam int SW = N + 1;

    logic [SW-1:0] sum;
    logic [NC:0]   raw;
    logic [SW-1:0] scaled;
    logic [SW-1:0] res;

    always_comb begin
        sum    = {1'b0, word} + SW'(err);
        raw    = sum[N:NF];
        sat    = raw[NC];
        coarse = sat ? {NC{1'b1}} : raw[NC-1:0];
        scaled = {1'b0, coarse, {NF{1'b0}}};
        res    = sum - scaled;
        err_next = (|res[N:NF]) ? {NF{1'b1}} : res[NF-1:0];
        fine   = FW'({1'b0, word} - scaled);
    end
endmodule

// File: rtl/rq_err_store.sv
module rq_err_store #(
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic [NF-1:0] err_d,
    output logic [NF-1:0] err_q
);
    always_ff @(posedge clk) begin
        if (rst)
            err_q <= '0;
        else if (load)
            err_q <= err_d;
    end

    AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
        !load |=> $stable(err_q)) else $error("error store moved without load"); // R8
    AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (err_q == '0)) else $error("error store not cleared"); // R1
endmodule

// File: rtl/coarse_fine_requant.sv
module coarse_fine_requant #(
    parameter int NC = 4,
    parameter int NF = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [NC-1:0] coarse_in,
    input  logic [NF-1:0] fine_in,
    output logic          out_valid,
    output logic [NC-1:0] coarse_out,
    output logic [NF:0]   fine_out
);
    import rq_pkg::*;

    localparam int N = NC + NF;

    logic [N-1:0]  word;
    logic [NF-1:0] err_q;
    logic [NF-1:0] err_d;
    logic [NC-1:0] coarse_d;
    logic [NF:0]   fine_d;
    logic          sat;
    rq_state_e     st_q;
    rq_state_e     st_d;

    assign word = {coarse_in, fine_in};

    rq_trunc #(.NC(NC), .NF(NF)) u_trunc (
        .word     (word),
        .err      (err_q),
        .coarse   (coarse_d),
        .fine     (fine_d),
        .err_next (err_d),
        .sat      (sat)
    );

    rq_err_store #(.NF(NF)) u_err (
        .clk   (clk),
        .rst   (rst),
        .load  (in_valid),
        .err_d (err_d),
        .err_q (err_q)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            RQ_IDLE: st_d = in_valid ? RQ_SHOW : RQ_IDLE;
            RQ_SHOW: st_d = in_valid ? RQ_SHOW : RQ_IDLE;
            default: st_d = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)
            st_q <= RQ_IDLE;
        else
            st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            coarse_out <= '0;
            fine_out   <= '0;
        end else if (in_valid) begin
            coarse_out <= coarse_d;
            fine_out   <= fine_d;
        end
    end

    assign out_valid = (st_q == RQ_SHOW);

    AST_VALID_AFTER_STROBE: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid) else $error("missing output strobe"); // R2
    AST_NO_SPURIOUS_VALID: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid) else $error("spurious output strobe"); // R2
    AST_EXACT_SPLIT: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (({1'b0, coarse_out, {NF{1'b0}}} + {{NC{fine_out[NF]}}, fine_out})
                       == {1'b0, $past(word)})) else $error("split does not rebuild word"); // R5
    AST_SAT_TOP: assert property (@(posedge clk) disable iff (rst)
        (in_valid && sat) |=> (coarse_out == {NC{1'b1}})) else $error("saturation lost"); // R7
    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> ($stable(coarse_out) && $stable(fine_out))) else $error("outputs moved"); // R8
    AST_RESET_STATE: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!out_valid && coarse_out == '0 && fine_out == '0)) else $error("reset state"); // R1
endmodule

// File: tb/sim_coarse_fine_requant.sv
module sim_coarse_fine_requant;
    localparam int NC = 4;
    localparam int NF = 4;
    localparam int SC = 1 << NF;
    localparam int MAXC = (1 << NC) - 1;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          in_valid = 1'b0;
    logic [NC-1:0] coarse_in = '0;
    logic [NF-1:0] fine_in = '0;
    logic          out_valid;
    logic [NC-1:0] coarse_out;
    logic [NF:0]   fine_out;

    int checks = 0;
    int fails = 0;
    int m_err = 0;
    int e_valid = 0;
    int e_coarse = 0;
    int e_fine = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    coarse_fine_requant #(.NC(NC), .NF(NF)) u0 (
        .clk(clk), .rst(rst), .in_valid(in_valid),
        .coarse_in(coarse_in), .fine_in(fine_in),
        .out_valid(out_valid), .coarse_out(coarse_out), .fine_out(fine_out)
    );

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic compare_all(input string req);
        check({req, " out_valid (R2)"}, int'(out_valid), e_valid);
        check({req, " coarse"}, int'(coarse_out), e_coarse);
        check({req, " fine (R5)"}, int'($signed(fine_out)), e_fine);
    endtask

    task automatic do_reset();
        rst = 1'b1; in_valid = 1'b0;
        repeat (2) @(posedge clk);
        #1;
        m_err = 0; e_valid = 0; e_coarse = 0; e_fine = 0;
        compare_all("R1 reset");
        rst = 1'b0;
    endtask

    // one clock: drive, advance the behavioural model, compare after the edge
    task automatic step(input bit v, input int c, input int f, input string req);
        int w, s, co, r;
        in_valid = v; coarse_in = NC'(c); fine_in = NF'(f);
        if (v) begin
            w = c * SC + f;
            s = w + m_err;
            co = s / SC;
            if (co > MAXC) co = MAXC;
            r = s - co * SC;
            if (r > SC - 1) r = SC - 1;
            m_err = r;
            e_coarse = co;
            e_fine = w - co * SC;
            e_valid = 1;
        end else begin
            e_valid = 0;
        end
        @(posedge clk);
        #1;
        compare_all(req);
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    endtask

    initial begin
        #400000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            report();
            $finish;
        end
    end

    initial begin
        int fsum, ups;
        @(negedge clk);
        do_reset();

        // R1, R4: first sample after reset uses zero error
        step(1'b1, 3, 15, "R1 first sample");
        check("R1 first coarse", int'(coarse_out), 3);
        check("R1 first fine", int'($signed(fine_out)), 15);

        // R9: constant input, shaping window from zero error
        do_reset();
        fsum = 0; ups = 0;
        for (int k = 0; k < SC; k++) begin
            step(1'b1, 2, 5, "R9 window");
            fsum += int'($signed(fine_out));
            if (int'(coarse_out) > 2) ups++;
        end
        check("R9 fine sum", fsum, 0);
        check("R9 coarse carries", ups, 5);

        // R3, R4, R5, R6: full ordered sweep of all words
        for (int w = 0; w < (1 << (NC + NF)); w++)
            step(1'b1, w / SC, w % SC, "R3 R4 R6 sweep");

        // R8: gaps hold outputs and error
        for (int k = 0; k < 40; k++) begin
            step(1'b1, k % (MAXC + 1), (k * 7) % SC, "R8 before gap");
            step(1'b0, 0, 9, "R8 gap");
            step(1'b0, MAXC, 1, "R8 gap 2");
        end

        // R7: saturation at the top word and near it
        for (int k = 0; k < 20; k++)
            step(1'b1, MAXC, SC - 1 - (k % 3), "R7 saturate");
        step(1'b1, MAXC, SC - 1, "R7 top");
        check("R7 coarse at max", int'(coarse_out), MAXC);
        step(1'b1, 0, 0, "R7 then zero");

        // mid-run reset then pseudo-random words with random strobes
        do_reset();
        for (int k = 0; k < 3000; k++)
            step(1'($urandom % 4 != 0), int'($urandom % (MAXC + 1)),
                 int'($urandom % SC), "R4 R5 R6 random");

        done = 1'b1;
        report();
        $finish;
    end
endmodule